// File: doc/BRIEF.md
# Operand Addressing Mode Fetch Unit

This sequential unit resolves and fetches a single instruction operand for a processor with 16-bit words and word addressing. The instruction sequencer hands it the already decoded fields of the first instruction word: a 4-bit register selector, a short-constant flag, a two-word format flag, a memory-operand flag, an indirect flag and an 8-bit constant. It also supplies the address of the first instruction word. The unit then works out the operand. It reads the extension word that follows the instruction when one is present, adds an index register, follows one pointer when indirection is requested and reads the memory operand.

A selector value of zero means that no register takes part. It does not mean register zero. The same field therefore switches between plain and indexed addressing, and in the one-word memory form it gives the address of the operand. When the operand is ready the unit raises `done` for one cycle. With it the unit presents the 16-bit operand, the effective address (so a later store can reuse it) and the instruction length in words, which the sequencer uses to advance its program counter. Register contents are read through a combinational register-file port. Memory is read through a port that returns data one cycle after the request.

Top module: `opnd_fetch_unit`

## Requirements
- R1: When `req_k8`=1 the operand is `req_imm` zero-extended to 16 bits, `eff_addr` is 0, `word_count` is 1 and no memory read is issued, whatever the other format flags are.
- R2: With `req_k8`=0, `req_long`=0 and `req_mem`=0, the operand is the content of the register that `req_r2` selects, `eff_addr` is 0, `word_count` is 1 and no memory read is issued.
- R3: The index value is the register content for a nonzero `req_r2` and 0 for `req_r2`=0. The register file is read through `rf_raddr`=`req_r2` in the accepting cycle.
- R4: With `req_k8`=0 and `req_long`=1, the unit reads the extension word from address `req_pc`+1, modulo 2^16, as its first memory read and reports `word_count`=2. With `req_mem`=0 the operand is extension word + index, modulo 2^16, and `eff_addr` is 0.
- R5: With `req_k8`=0, `req_long`=0 and `req_mem`=1, the unit makes exactly one memory read, at the index value. The operand is that word and `eff_addr` is the index value.
- R6: With `req_k8`=0, `req_long`=1, `req_mem`=1 and `req_indir`=0, the effective address is extension word + index, modulo 2^16. The operand is read there, for two reads in total.
- R7: With `req_k8`=0, `req_long`=1, `req_mem`=1 and `req_indir`=1, the word at address extension word + index (modulo 2^16) is the effective address. The operand is read from that address, for three reads in total.
- R8: `req_indir` has no effect in the one-word formats (`req_long`=0). `req_long`, `req_mem` and `req_indir` have no effect when `req_k8`=1.
- R9: Count the cycle that begins at the accepting clock edge as cycle 1. `done` is then high in cycle 1 for R1 and R2, in cycle 3 for R4 immediate and for R5, in cycle 5 for R6 and in cycle 7 for R7.
- R10: `done` is high for exactly one cycle per request. While `busy` is low, `operand`, `eff_addr` and `word_count` keep their values.
- R11: A request is accepted only at a clock edge where `req_valid`=1 and `busy`=0. A `req_valid` seen while `busy` is high is ignored and changes no result.
- R12: During and right after reset, `busy`, `done` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_k8 | input | 1 | Short-constant format |
| req_long | input | 1 | Two-word format (extension word follows) |
| req_mem | input | 1 | Operand is held in memory |
| req_indir | input | 1 | One level of indirection (two-word memory format only) |
| req_r2 | input | 4 | Register selector, 0 = no register |
| req_imm | input | 8 | Low byte of the instruction word |
| req_pc | input | 16 | Address of the first instruction word |
| busy | output | 1 | A request is in progress |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 16 | Register-file read data, combinational |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |
| done | output | 1 | One-cycle result strobe |
| operand | output | 16 | Fetched operand |
| eff_addr | output | 16 | Final operand address for memory forms, else 0 |
| word_count | output | 2 | Instruction length in words (1 or 2) |

## Verification
The checker assumes that the register file answers in the same cycle and that memory answers exactly one cycle after each `mem_rd_en`. It also assumes the format flags are valid in the cycle a request is accepted. The bench models both ports this way, with content computed from the address, and drives each request for one cycle at a moment when `busy` is low. On some requests it keeps `req_valid` high with changed fields for the whole busy period. These requests test R11 without leaving the stated input contract at the accepting edge.

// File: rtl/opnd_fetch_pkg.sv
package opnd_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_EXT_FETCH = 3'd1,
    ST_PTR_READ  = 3'd2,
    ST_OPND_READ = 3'd3,
    ST_DONE      = 3'd4
  } fetch_state_e;

endpackage

// File: rtl/opnd_index_sel.sv
// Index value: register content, or zero when the selector names no register.
module opnd_index_sel #(
  parameter int W      = 16,
  parameter int RSEL_W = 4
) (
  input  logic [RSEL_W-1:0] sel,
  input  logic [W-1:0]      reg_val,
  output logic [W-1:0]      idx
);

  logic no_reg;

  always_comb begin
    no_reg = (sel == '0);
    idx    = no_reg ? '0 : reg_val;
  end

endmodule

// File: rtl/opnd_fetch_ctrl.sv
// Sequencer: every read state spends one issue cycle and one data cycle.
module opnd_fetch_ctrl
  import opnd_fetch_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_k8,
  input  logic         req_long,
  input  logic         req_mem,
  input  logic         req_indir,
  output fetch_state_e state_q,
  output logic         accept,
  output logic         rd_issue,
  output logic         rd_step,
  output logic         mode_mem_q
);

  fetch_state_e state_d;
  logic         phase_q, phase_d;
  logic         indir_q;
  logic         mode_mem_d, indir_d;
  logic         is_rd;

  always_comb begin
    accept     = req_valid && (state_q == ST_IDLE);
    is_rd      = (state_q == ST_EXT_FETCH) || (state_q == ST_PTR_READ) ||
                 (state_q == ST_OPND_READ);
    rd_issue   = is_rd && !phase_q;
    rd_step    = is_rd && phase_q;
    phase_d    = is_rd ? !phase_q : 1'b0;
    mode_mem_d = req_mem && !req_k8;
    indir_d    = req_indir && req_long && !req_k8;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_k8 || (!req_long && !req_mem)) state_d = ST_DONE;
          else if (!req_long)                    state_d = ST_OPND_READ;
          else                                   state_d = ST_EXT_FETCH;
        end
      end
      ST_EXT_FETCH: begin
        if (rd_step) begin
          if (!mode_mem_q)   state_d = ST_DONE;
          else if (indir_q)  state_d = ST_PTR_READ;
          else               state_d = ST_OPND_READ;
        end
      end
      ST_PTR_READ:  if (rd_step) state_d = ST_OPND_READ;
      ST_OPND_READ: if (rd_step) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_mem_q <= 1'b0;
      indir_q    <= 1'b0;
    end else if (accept) begin
      mode_mem_q <= mode_mem_d;
      indir_q    <= indir_d;
    end
  end

endmodule

// File: rtl/opnd_fetch_dpath.sv
// Address and result registers with explicit load enables.
module opnd_fetch_dpath
  import opnd_fetch_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fetch_state_e state_q,
  input  logic         accept,
  input  logic         rd_step,
  input  logic         mode_mem_q,
  input  logic         req_k8,
  input  logic         req_long,
  input  logic         req_mem,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [W-1:0] req_pc,
  input  logic [W-1:0] idx,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] operand,
  output logic [W-1:0] eff_addr,
  output logic [1:0]   word_count
);

  localparam int PAD_W = W - IMM_W;

  logic [W-1:0] pc_q, idx_q, addr_q, opnd_q, ea_q;
  logic [1:0]   wc_q;
  logic [W-1:0] addr_d, opnd_d, ea_d, sum_ext;
  logic [1:0]   wc_d;
  logic         ld_addr, ld_opnd, ld_ea;

  always_comb begin
    sum_ext = mem_rdata + idx_q;
    wc_d    = (req_long && !req_k8) ? 2'd2 : 2'd1;

    ld_addr = 1'b0;
    addr_d  = addr_q;
    ld_opnd = 1'b0;
    opnd_d  = opnd_q;
    ld_ea   = 1'b0;
    ea_d    = ea_q;

    if (accept) begin
      ld_addr = 1'b1;
      addr_d  = idx;
      ld_opnd = 1'b1;
      ld_ea   = 1'b1;
      ea_d    = '0;
      if (req_k8)                     opnd_d = {{PAD_W{1'b0}}, req_imm};
      else if (!req_long && !req_mem) opnd_d = idx;
      else                            opnd_d = '0;
    end else if (rd_step) begin
      unique case (state_q)
        ST_EXT_FETCH: begin
          ld_addr = 1'b1;
          addr_d  = sum_ext;
          if (!mode_mem_q) begin
            ld_opnd = 1'b1;
            opnd_d  = sum_ext;
          end
        end
        ST_PTR_READ: begin
          ld_addr = 1'b1;
          addr_d  = mem_rdata;
        end
        ST_OPND_READ: begin
          ld_opnd = 1'b1;
          opnd_d  = mem_rdata;
          ld_ea   = 1'b1;
          ea_d    = addr_q;
        end
        default: ;
      endcase
    end

    mem_addr = (state_q == ST_EXT_FETCH) ? pc_q + W'(1) : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      idx_q <= '0;
      wc_q  <= 2'd1;
    end else if (accept) begin
      pc_q  <= req_pc;
      idx_q <= idx;
      wc_q  <= wc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (ld_addr) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opnd_q <= '0;
    else if (ld_opnd) opnd_q <= opnd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ea_q <= '0;
    else if (ld_ea) ea_q <= ea_d;
  end

  assign operand    = opnd_q;
  assign eff_addr   = ea_q;
  assign word_count = wc_q;

endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
  import opnd_fetch_pkg::*;
#(
  parameter int W      = 16,
  parameter int RSEL_W = 4,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_k8,
  input  logic              req_long,
  input  logic              req_mem,
  input  logic              req_indir,
  input  logic [RSEL_W-1:0] req_r2,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [W-1:0]      req_pc,
  output logic              busy,
  output logic [RSEL_W-1:0] rf_raddr,
  input  logic [W-1:0]      rf_rdata,
  output logic              mem_rd_en,
  output logic [W-1:0]      mem_addr,
  input  logic [W-1:0]      mem_rdata,
  output logic              done,
  output logic [W-1:0]      operand,
  output logic [W-1:0]      eff_addr,
  output logic [1:0]        word_count
);

  fetch_state_e state_q;
  logic         accept, rd_issue, rd_step, mode_mem_q;
  logic [W-1:0] idx;

  opnd_index_sel #(.W(W), .RSEL_W(RSEL_W)) u_idx (
    .sel     (req_r2),
    .reg_val (rf_rdata),
    .idx     (idx)
  );

  opnd_fetch_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_k8     (req_k8),
    .req_long   (req_long),
    .req_mem    (req_mem),
    .req_indir  (req_indir),
    .state_q    (state_q),
    .accept     (accept),
    .rd_issue   (rd_issue),
    .rd_step    (rd_step),
    .mode_mem_q (mode_mem_q)
  );

  opnd_fetch_dpath #(.W(W), .IMM_W(IMM_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .accept     (accept),
    .rd_step    (rd_step),
    .mode_mem_q (mode_mem_q),
    .req_k8     (req_k8),
    .req_long   (req_long),
    .req_mem    (req_mem),
    .req_imm    (req_imm),
    .req_pc     (req_pc),
    .idx        (idx),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .operand    (operand),
    .eff_addr   (eff_addr),
    .word_count (word_count)
  );

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign rf_raddr  = req_r2;
  assign mem_rd_en = rd_issue;

endmodule

// File: rtl/opnd_fetch_unit_chk.sv
module opnd_fetch_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_k8,
  input logic         req_long,
  input logic         req_mem,
  input logic [W-1:0] req_pc,
  input logic         busy,
  input logic         mem_rd_en,
  input logic [W-1:0] mem_addr,
  input logic         done,
  input logic [W-1:0] operand,
  input logic [W-1:0] eff_addr,
  input logic [1:0]   word_count
);

  logic         c_k8, c_long, c_mem, first_rd;
  logic [W-1:0] c_pc, last_addr;
  logic         acc;

  assign acc = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_k8 <= 1'b0; c_long <= 1'b0; c_mem <= 1'b0;
      first_rd <= 1'b0; c_pc <= '0; last_addr <= '0;
    end else begin
      if (acc) begin
        c_k8 <= req_k8; c_long <= req_long; c_mem <= req_mem;
        c_pc <= req_pc; first_rd <= 1'b1;
      end else if (mem_rd_en) begin
        first_rd <= 1'b0;
      end
      if (mem_rd_en) last_addr <= mem_addr;
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(operand) && $stable(eff_addr) && $stable(word_count)));

  p_read_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  p_start_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  p_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (!c_k8 && (c_long || c_mem)));

  p_ea_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (c_k8 || !c_mem)) |-> (eff_addr == '0));

  p_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_count == ((c_long && !c_k8) ? 2'd2 : 2'd1)));

  p_ext_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && first_rd && c_long && !c_k8) |-> (mem_addr == c_pc + W'(1)));

  p_ea_last_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !c_k8 && c_mem) |-> (eff_addr == last_addr));

endmodule

bind opnd_fetch_unit opnd_fetch_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_k8     (req_k8),
  .req_long   (req_long),
  .req_mem    (req_mem),
  .req_pc     (req_pc),
  .busy       (busy),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .done       (done),
  .operand    (operand),
  .eff_addr   (eff_addr),
  .word_count (word_count)
);

// File: tb/opnd_fetch_unit_test.sv
`timescale 1ns/100ps
module opnd_fetch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_k8 = 1'b0, req_long = 1'b0;
  logic        req_mem = 1'b0, req_indir = 1'b0;
  logic [3:0]  req_r2 = '0;
  logic [7:0]  req_imm = '0;
  logic [15:0] req_pc = '0;
  logic        busy, mem_rd_en, done;
  logic [3:0]  rf_raddr;
  logic [15:0] rf_rdata, mem_addr, operand, eff_addr;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  word_count;

  always #2.5 clk = ~clk;

  opnd_fetch_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_k8(req_k8),
    .req_long(req_long), .req_mem(req_mem), .req_indir(req_indir),
    .req_r2(req_r2), .req_imm(req_imm), .req_pc(req_pc), .busy(busy),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .operand(operand), .eff_addr(eff_addr), .word_count(word_count)
  );

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return ({a[7:0], a[15:8]} ^ 16'h5A3C) + 16'h0123;
  endfunction

  function automatic logic [15:0] rf_f(input logic [3:0] r);
    return 16'hF000 | ({12'h0, r} * 16'h0111);
  endfunction

  assign rf_rdata = rf_f(rf_raddr);
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_f(mem_addr);

  typedef struct {
    logic [15:0] op;
    logic [15:0] ea;
    logic [1:0]  wc;
    int          lat;
    int          reads;
    int          start;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, cyc = 0, rd_cnt = 0;
  bit   pend_pulse = 0, finished = 0;
  logic [15:0] last_op;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic issue(input bit k8, input bit lng, input bit mem, input bit ind,
                       input logic [3:0] r2, input logic [7:0] imm,
                       input logic [15:0] pc, input bit noise, input string tag);
    exp_t e;
    logic [15:0] idx, ext;
    idx = (r2 == 4'd0) ? 16'h0 : rf_f(r2);
    ext = mem_f(pc + 16'd1);
    e.tag = tag;
    if (k8) begin
      e.op = {8'h00, imm}; e.ea = 0; e.wc = 1; e.lat = 1; e.reads = 0;
    end else if (!lng && !mem) begin
      e.op = idx; e.ea = 0; e.wc = 1; e.lat = 1; e.reads = 0;
    end else if (!lng) begin
      e.ea = idx; e.op = mem_f(idx); e.wc = 1; e.lat = 3; e.reads = 1;
    end else if (!mem) begin
      e.op = ext + idx; e.ea = 0; e.wc = 2; e.lat = 3; e.reads = 1;
    end else if (!ind) begin
      e.ea = ext + idx; e.op = mem_f(e.ea); e.wc = 2; e.lat = 5; e.reads = 2;
    end else begin
      e.ea = mem_f(ext + idx); e.op = mem_f(e.ea); e.wc = 2; e.lat = 7; e.reads = 3;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    req_k8 = k8; req_long = lng; req_mem = mem; req_indir = ind;
    req_r2 = r2; req_imm = imm; req_pc = pc; req_valid = 1'b1;
    e.start = cyc + 1;
    exp_q.push_back(e);
    last_op = e.op;
    @(negedge clk);
    if (noise) begin
      while (busy) begin
        req_k8 = ~req_k8; req_long = ~req_long; req_r2 = req_r2 + 4'd3;
        req_imm = req_imm + 8'h11; req_pc = req_pc + 16'h0101;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard on each result strobe.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_rd_en) rd_cnt++;
      if (pend_pulse) begin
        chk(!done, "R10 done width", done, 0);
        pend_pulse = 0;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(operand == e.op, {e.tag, " operand"}, operand, e.op);
          chk(eff_addr == e.ea, {e.tag, " eff_addr"}, eff_addr, e.ea);
          chk(word_count == e.wc, {e.tag, " word_count"}, word_count, e.wc);
          chk(rd_cnt == e.reads, {e.tag, " read count"}, rd_cnt, e.reads);
          chk((cyc - e.start + 1) == e.lat, {e.tag, " R9 latency"}, cyc - e.start + 1, e.lat);
        end
        rd_cnt = 0;
        pend_pulse = 1;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R12 in reset", {busy, done, mem_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R12 after reset", {busy, done, mem_rd_en}, 0);

    issue(1, 1, 1, 1, 4'd6, 8'hA7, 16'h0040, 0, "R1/R8 k8 flags set");
    issue(1, 0, 0, 0, 4'd0, 8'hFF, 16'h0000, 0, "R1 k8");
    issue(0, 0, 0, 0, 4'd5, 8'h00, 16'h0000, 0, "R2 reg");
    issue(0, 0, 0, 0, 4'd0, 8'h00, 16'h0000, 0, "R3 reg zero sel");
    issue(0, 0, 1, 1, 4'd3, 8'h00, 16'h0000, 0, "R5/R8 short mem");
    issue(0, 0, 1, 0, 4'd0, 8'h00, 16'h0000, 0, "R3/R5 short mem addr0");
    issue(0, 1, 0, 0, 4'd0, 8'h00, 16'h1234, 0, "R4 long imm");
    issue(0, 1, 0, 0, 4'd7, 8'h00, 16'hFFFF, 0, "R4 long imm pc wrap");
    issue(0, 1, 1, 0, 4'd0, 8'h00, 16'h2000, 0, "R6 long direct");
    issue(0, 1, 1, 0, 4'd9, 8'h00, 16'h3456, 0, "R6 indexed wrap");
    issue(0, 1, 1, 1, 4'd0, 8'h00, 16'h0777, 0, "R7 indirect");
    issue(0, 1, 1, 1, 4'd12, 8'h00, 16'hABCD, 1, "R7/R11 idx indirect noise");
    issue(0, 0, 1, 0, 4'd14, 8'h00, 16'h0000, 1, "R11 short mem noise");
    issue(1, 0, 0, 0, 4'd2, 8'h3C, 16'h0000, 1, "R11 k8 noise");

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(operand == last_op, "R10 idle hold", operand, last_op);
    chk(exp_q.size() == 0, "R9 outstanding results", exp_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule